// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Front End

This block is the digital front end of a single-channel voltage-output converter with a byte-wide parallel bus. A host selects the block with an active-low select, and each rising edge of an active-low write strobe stores one byte into an input register. A high-byte enable chooses where that byte goes. With the enable low, the byte becomes the low code bits. With it high, the byte supplies the upper code bits together with a reference-buffer enable bit and a gain bit. This lets a 12-bit code be built from two writes.

A second register, the DAC register, drives the converter. It is loaded from the input register by an active-low load strobe, but only when the input register has been written since the last transfer. Holding the load strobe low gives synchronous operation: every write then reaches the converter. An active-low clear zeroes both registers at once, without waiting for a clock edge. A power-down input only removes the output enable, so the analog output can be treated as high impedance.

The strobes are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the write edge is detected after synchronisation. Because of this, every strobe level must last at least three clocks.

Top module: `dac_dbuf_front`

## Requirements
- R1: A write is taken only on a rising edge of `wr_n` while `cs_n` is low; a strobe with `cs_n` high changes no register and leaves nothing pending.
- R2: A write with `hi_byte` low loads `bus_d[7:0]` into code bits 7..0 of the input register and keeps the upper bits.
- R3: A write with `hi_byte` high loads `bus_d[3:0]` into code bits 11..8, `bus_d[4]` into the reference-buffer bit and `bus_d[5]` into the gain bit; `bus_d[7:6]` are ignored and code bits 7..0 are kept.
- R4: While `ld_n` is high, `dac_code`, `dac_gain2` and `dac_refbuf` hold their values, whatever writes take place.
- R5: A low `ld_n` copies the code, gain and buffer bits of the input register into the DAC register when a write has happened since the previous transfer.
- R6: A low `ld_n` with no write since the previous transfer leaves the DAC register unchanged.
- R7: With `ld_n` held low, every write reaches the DAC outputs, one transfer per write.
- R8: A low `clr_n` zeroes both registers and the pending state at once, with no clock edge needed, and overrides every other input.
- R9: After reset, the code is zero, the reference buffer is off (0) and the gain is 1 (gain bit 0).
- R10: `out_en` follows `pd_n`; power-down changes neither register, and transfers still happen during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe; data is taken on its rising edge |
| ld_n | input | 1 | Active-low load strobe for the DAC register |
| clr_n | input | 1 | Active-low asynchronous clear of both registers |
| hi_byte | input | 1 | 1 selects the upper-byte write, 0 the lower byte |
| bus_d | input | 8 | Parallel data bus |
| pd_n | input | 1 | Active-low power-down |
| dac_code | output | 12 | Code held in the DAC register |
| dac_gain2 | output | 1 | Gain bit of the DAC register (1 selects double range) |
| dac_refbuf | output | 1 | Reference-buffer bit of the DAC register |
| out_en | output | 1 | Analog output enable |

## Verification
The bench writes the two byte halves in both orders, with random values on the unused lines 7..6. A design that decoded those lines, or swapped the control bit positions, shows a wrong gain or buffer bit. It writes with the select high and then loads. A design that ignored the select, or set the pending state on a deselected strobe, would change the output. It also issues repeated loads after a single write, which a design without the pending condition could get wrong. The bench holds the load strobe low across several writes to show that each new value reaches the output, and it pulses the clear mid-cycle and checks for zeros within a nanosecond, before any clock edge. It toggles power-down around writes and loads, where a design that gated the registers with power-down would freeze or clear the code.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

   // Control bits that travel with the code through both registers.
   typedef struct packed {
      logic gain2;
      logic ref_buf;
   } dac_ctl_t;

   localparam dac_ctl_t CTL_RESET = '{gain2: 1'b0, ref_buf: 1'b0};

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("strobe_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dac_input_reg.sv
module dac_input_reg
   import dac_fe_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              wr_ev,
   input  logic              hi_byte,
   input  logic [BYTE_W-1:0] bus_d,
   output logic [CODE_W-1:0] in_code,
   output dac_ctl_t          in_ctl
);

   localparam int HI_W     = CODE_W - BYTE_W;
   localparam int BUF_POS  = HI_W;
   localparam int GAIN_POS = HI_W + 1;

   if (HI_W < 1) begin : g_bad_split
      $error("code must be wider than one bus byte");
   end
   if (GAIN_POS >= BYTE_W) begin : g_bad_ctl
      $error("upper byte has no room for the control bits");
   end

   logic [BYTE_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;
   dac_ctl_t          ctl_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         ctl_q <= CTL_RESET;
      end else if (wr_ev) begin
         if (hi_byte) begin
            hi_q          <= bus_d[HI_W-1:0];
            ctl_q.ref_buf <= bus_d[BUF_POS];
            ctl_q.gain2   <= bus_d[GAIN_POS];
         end else begin
            lo_q <= bus_d;
         end
      end
   end

   assign in_code = {hi_q, lo_q};
   assign in_ctl  = ctl_q;

endmodule

// File: rtl/dac_xfer_reg.sv
module dac_xfer_reg
   import dac_fe_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              wr_ev,
   input  logic              ld_low,
   input  logic [CODE_W-1:0] in_code,
   input  dac_ctl_t          in_ctl,
   output logic [CODE_W-1:0] dac_code,
   output dac_ctl_t          dac_ctl,
   output logic              pend_o
);

   logic              pend_q;
   logic              xfer;
   logic [CODE_W-1:0] code_q;
   dac_ctl_t          ctl_q;

   assign xfer = ld_low & pend_q;

   // A write in the same cycle as a transfer keeps the flag set, so
   // the newer value follows one cycle later.
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    pend_q <= 1'b0;
      else if (wr_ev) pend_q <= 1'b1;
      else if (xfer)  pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         code_q <= '0;
         ctl_q  <= CTL_RESET;
      end else if (xfer) begin
         code_q <= in_code;
         ctl_q  <= in_ctl;
      end
   end

   assign dac_code = code_q;
   assign dac_ctl  = ctl_q;
   assign pend_o   = pend_q;

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
   import dac_fe_pkg::*;
#(
   parameter int CODE_W      = 12,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic              clr_n,
   input  logic              hi_byte,
   input  logic [BYTE_W-1:0] bus_d,
   input  logic              pd_n,
   output logic [CODE_W-1:0] dac_code,
   output logic              dac_gain2,
   output logic              dac_refbuf,
   output logic              out_en
);

   localparam int N_STB = 3;
   localparam int I_CS  = 0;
   localparam int I_WR  = 1;
   localparam int I_LD  = 2;

   logic [N_STB-1:0] stb_raw;
   logic [N_STB-1:0] stb_sync;
   logic             wr_d;
   logic             wr_ev;
   logic             ld_low;
   logic             arst_n;
   logic             pend;
   logic [CODE_W-1:0] in_code;
   dac_ctl_t         in_ctl;
   dac_ctl_t         out_ctl;

   assign stb_raw = {ld_n, wr_n, cs_n};

   for (genvar i = 0; i < N_STB; i++) begin : g_sync
      strobe_sync #(
         .STAGES   (SYNC_STAGES),
         .RESET_VAL(1'b1)
      ) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_in(stb_raw[i]),
         .sync_o  (stb_sync[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_d <= 1'b1;
      else        wr_d <= stb_sync[I_WR];
   end

   assign wr_ev  = stb_sync[I_WR] & ~wr_d & ~stb_sync[I_CS];
   assign ld_low = ~stb_sync[I_LD];
   assign arst_n = rst_n & clr_n;

   dac_input_reg #(
      .CODE_W(CODE_W),
      .BYTE_W(BYTE_W)
   ) u_in (
      .clk    (clk),
      .arst_n (arst_n),
      .wr_ev  (wr_ev),
      .hi_byte(hi_byte),
      .bus_d  (bus_d),
      .in_code(in_code),
      .in_ctl (in_ctl)
   );

   dac_xfer_reg #(
      .CODE_W(CODE_W)
   ) u_dac (
      .clk     (clk),
      .arst_n  (arst_n),
      .wr_ev   (wr_ev),
      .ld_low  (ld_low),
      .in_code (in_code),
      .in_ctl  (in_ctl),
      .dac_code(dac_code),
      .dac_ctl (out_ctl),
      .pend_o  (pend)
   );

   assign dac_gain2  = out_ctl.gain2;
   assign dac_refbuf = out_ctl.ref_buf;
   assign out_en     = pd_n;

endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk #(
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic              ld_low,
   input logic              pend,
   input logic              wr_ev,
   input logic [CODE_W-1:0] in_code,
   input logic [CODE_W-1:0] dac_code,
   input logic              dac_gain2,
   input logic              dac_refbuf
);

   // R8: clear forces zeros on the DAC outputs
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (dac_code == '0 && !dac_gain2 && !dac_refbuf));

   // R4: no load, no change
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !ld_low |=> $stable(dac_code));

   // R5: load with pending copies the input code
   a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (ld_low && pend) |=> dac_code == $past(in_code));

   // R6: load without pending has no effect
   a_r6_no_stale: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (ld_low && !pend) |=> $stable(dac_code));

   // R1: input register changes only after a qualified write
   a_r1_write_only: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !$stable(in_code) |-> $past(wr_ev));

endmodule

bind dac_dbuf_front dac_fe_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_n     (clr_n),
   .ld_low    (ld_low),
   .pend      (pend),
   .wr_ev     (wr_ev),
   .in_code   (in_code),
   .dac_code  (dac_code),
   .dac_gain2 (dac_gain2),
   .dac_refbuf(dac_refbuf)
);

// File: tb/tb_dac_dbuf_front.sv
`timescale 1ns/1ps
module tb_dac_dbuf_front;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       ld_n = 1'b1;
   logic       clr_n = 1'b1;
   logic       hi_byte = 1'b0;
   logic [7:0] bus_d = 8'h00;
   logic       pd_n = 1'b1;
   logic [11:0] dac_code;
   logic       dac_gain2;
   logic       dac_refbuf;
   logic       out_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // model state
   logic [11:0] m_in;
   logic        m_in_g, m_in_b;
   logic [11:0] m_dac;
   logic        m_g, m_b;
   bit          m_pend;

   always #4 clk = ~clk;

   dac_dbuf_front dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
      .clr_n(clr_n), .hi_byte(hi_byte), .bus_d(bus_d), .pd_n(pd_n),
      .dac_code(dac_code), .dac_gain2(dac_gain2), .dac_refbuf(dac_refbuf),
      .out_en(out_en)
   );

   function automatic logic [14:0] pack_exp(logic en, logic g, logic b, logic [11:0] c);
      return {en, g, b, c};
   endfunction

   task automatic check(string tag, logic [14:0] got, logic [14:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_out(string tag);
      check(tag, {out_en, dac_gain2, dac_refbuf, dac_code},
            pack_exp(pd_n, m_g, m_b, m_dac));
   endtask

   task automatic clks(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic model_clear();
      m_in = '0; m_in_g = 0; m_in_b = 0;
      m_dac = '0; m_g = 0; m_b = 0; m_pend = 0;
   endtask

   task automatic model_xfer();
      if (m_pend) begin
         m_dac = m_in; m_g = m_in_g; m_b = m_in_b; m_pend = 0;
      end
   endtask

   // selected: 1 drives cs_n low around the strobe
   task automatic do_write(bit hi, logic [7:0] d, bit selected);
      @(negedge clk);
      hi_byte = hi; bus_d = d; cs_n = !selected;
      clks(3);
      wr_n = 1'b0;
      clks(4);
      wr_n = 1'b1;
      clks(5);
      cs_n = 1'b1;
      bus_d = $urandom;
      clks(3);
      if (selected) begin
         if (hi) begin
            m_in[11:8] = d[3:0]; m_in_b = d[4]; m_in_g = d[5];
         end else begin
            m_in[7:0] = d;
         end
         m_pend = 1;
         if (ld_n == 1'b0) model_xfer();
      end
   endtask

   task automatic do_load();
      @(negedge clk);
      ld_n = 1'b0;
      clks(4);
      ld_n = 1'b1;
      clks(4);
      model_xfer();
   endtask

   initial begin
      model_clear();
      clks(3);
      rst_n = 1'b1;
      clks(2);
      check_out("R9 reset state");

      // R2/R3: both halves, then load
      do_write(0, 8'hA5, 1);
      check_out("R4 low write without load keeps outputs");
      do_write(1, 8'hFB, 1);   // bits 7:6 set, gain=1, buf=1, hi=B
      do_load();
      check_out("R3 R5 upper byte with control bits");
      check(("R2 low byte"), {7'd0, dac_code[7:0]}, {7'd0, 8'hA5});
      do_write(1, 8'h13, 1);   // gain 0 buf 1 hi 3
      do_write(0, 8'h3C, 1);
      check_out("R4 hold during writes");
      do_load();
      check_out("R5 transfer after reversed order");
      // R6: loads with nothing new
      do_load();
      check_out("R6 repeated load no effect");
      do_load();
      check_out("R6 second repeated load");
      // R1: deselected write then load
      do_write(0, 8'h77, 0);
      do_load();
      check_out("R1 deselected write ignored");
      // R7: load held low
      @(negedge clk); ld_n = 1'b0; clks(4);
      do_write(0, 8'h11, 1);
      check_out("R7 sync low byte");
      do_write(1, 8'h29, 1);
      check_out("R7 sync upper byte");
      do_write(0, 8'hEE, 1);
      check_out("R7 sync third write");
      @(negedge clk); ld_n = 1'b1; clks(4);
      // R10: power down
      pd_n = 1'b0; clks(2);
      check_out("R10 power-down output enable");
      do_write(0, 8'h5A, 1);
      do_load();
      check_out("R10 transfer during power-down");
      pd_n = 1'b1; clks(2);
      check_out("R10 power-up keeps code");
      // R8: clear mid-cycle with load low and a write pending
      do_write(1, 8'h0F, 1);
      @(posedge clk); #2;
      clr_n = 1'b0; ld_n = 1'b0;
      #1;
      model_clear();
      check_out("R8 clear immediate");
      clks(4);
      check_out("R8 clear overrides load");
      clr_n = 1'b1; ld_n = 1'b1; clks(4);
      do_load();
      check_out("R8 nothing pending after clear");

      // random mix
      for (int k = 0; k < 70; k++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0, 1: do_write(op[0], 8'($urandom), 1);
            2:    do_write(1'($urandom), 8'($urandom), 0);
            3:    do_load();
            4:    begin pd_n = ~pd_n; clks(2); end
            default: begin
               do_write(1'($urandom), 8'($urandom), 1);
               do_load();
            end
         endcase
         check_out("R5 random sequence");
      end
      pd_n = 1'b1;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed_1234);
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule